// File: doc/BRIEF.md
# Four-Symbol ECC Correction Sequencer

This block drives the correction phase for one 512-byte sector protected by a code that can repair up to four symbols. The caller pulses `start` with the ten stored check bytes on `ecc_code`. The block unpacks those bytes into eight 10-bit values and feeds them to an external syndrome engine. It reads back the syndrome. When the syndrome is non-zero, it asks the engine to locate the errors. It then waits for the engine to settle, fetches up to four address/value pairs and issues XOR strokes to the sector buffer that holds the data just read.

The engine's arithmetic is outside this block. All engine registers are reached through one read port (`eng_rd_en`, `eng_rd_sel`, `eng_rd_data`, with data returned in the same cycle), one write-only load port and a single start strobe. A read strobe counts as an access at the clock edge where it is high. Some engine registers clear themselves or close a calculation when they are read, so every read the block issues is deliberate.

States: IDLE waits for `start`. LOAD writes the eight values. SYND reads the four syndrome words. CLEAR issues a dummy read of the first address register. KICK pulses the location start. ARM waits out the false "complete" code. POLL waits for a final code. TERM issues a closing dummy read of the first value register. FADDR and FVAL fetch one error address and then its value. DONE raises the completion pulse.

Transitions:
- IDLE goes to DONE on an erased code, or to LOAD otherwise.
- LOAD goes to SYND after value 0.
- SYND goes to DONE on a zero syndrome, or to CLEAR otherwise.
- CLEAR goes to KICK, and KICK goes to ARM.
- ARM goes to POLL once the code is 4 or more, or once the timer expires.
- POLL goes to TERM on code 0 or 1, or to FADDR on code 2 or 3.
- TERM goes to DONE.
- FADDR goes to FVAL.
- FVAL goes to FADDR while errors remain, or to DONE after the last one.
- DONE goes to IDLE.

Top module: `ecc4_corr_seq`

## Requirements
- R1: If all ten bytes of `ecc_code` equal 0xFF, the block raises `done` one cycle after `start` with `corr_cnt`=0 and `uncorrectable`=0. It makes no load, read or start access to the engine.
- R2: Value k is taken from bits 10k+9..10k of `ecc_code`, where byte 0 sits in bits 7..0. The eight values are presented on `eng_load_data` with `eng_load_valid` high, one per cycle, value 7 first and value 0 last.
- R3: After loading, the block reads selects 0,1,2,3 (syndrome words). Each word is masked with 0x03FF03FF. If all masked words are zero, `done` follows with no corrections, and the block issues no location start.
- R4: Before `eng_calc_start` is pulsed, the read in the immediately preceding cycle is of select 4 (address pair A). `eng_calc_start` is high for exactly one cycle.
- R5: Status is read at select 8, with the code in bits 11:8 and the count field in bits 17:16. After the start pulse, codes 2 and 3 are not accepted until a code of 4 or more has been seen, or until WAIT_LIMIT cycles have passed in the arming wait.
- R6: Final code 0 ends with no corrections and `uncorrectable`=0. Code 1 ends with `uncorrectable`=1 and no XOR stroke. Both are preceded by a read of select 6.
- R7: Codes 2 and 3 give 1 plus the count field as the number of errors. Errors 0 and 1 use address select 4 and value select 6. Errors 2 and 3 use selects 5 and 7. Even errors take bits 15:0 and odd errors take bits 31:16. The address is the low 10 bits and the value the low 8 bits.
- R8: An error address a maps to byte index 519−a. Only indices 0..511 receive an XOR stroke (`buf_xor_en`, `buf_xor_idx`, `buf_xor_val`), and only those are counted in `corr_cnt`.
- R9: `done` is a single-cycle pulse. `corr_cnt` and `uncorrectable` keep their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin correction of one sector (accepted in IDLE) |
| ecc_code | input | 80 | Ten stored check bytes, byte 0 in bits 7:0 |
| eng_load_valid | output | 1 | Load strobe to the syndrome engine |
| eng_load_data | output | 10 | Value being loaded |
| eng_calc_start | output | 1 | Error-location start pulse |
| eng_rd_en | output | 1 | Engine register read strobe |
| eng_rd_sel | output | 4 | Engine register select |
| eng_rd_data | input | 32 | Read data for the selected register, same cycle |
| buf_xor_en | output | 1 | XOR stroke into the sector buffer |
| buf_xor_idx | output | 9 | Byte index of the stroke |
| buf_xor_val | output | 8 | Mask XORed into that byte |
| done | output | 1 | Completion pulse |
| corr_cnt | output | 3 | Bytes corrected for the last sector |
| uncorrectable | output | 1 | Last sector had five or more errors |

## Verification
The bench builds the block with WAIT_LIMIT set to 16 instead of its default of 200. This lets a run where the engine never leaves its false "complete" code reach the timer escape within a few dozen cycles. Sector size, symbol width and byte count stay at their defaults. That keeps the 519−a mapping and both out-of-range edges, 512..519 and negative results, reachable with real addresses. The stub engine holds address registers at zero until it reports a genuine result. A sequencer that accepted the false code early would therefore strike byte 519−0, which is outside the sector, and miss the expected correction.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_SYND,
        S_CLEAR,
        S_KICK,
        S_ARM,
        S_POLL,
        S_TERM,
        S_FADDR,
        S_FVAL,
        S_DONE
    } seq_state_t;

    // engine register selects
    localparam logic [3:0] SEL_SYN0   = 4'd0;
    localparam logic [3:0] SEL_ADDR_A = 4'd4;
    localparam logic [3:0] SEL_ADDR_B = 4'd5;
    localparam logic [3:0] SEL_VAL_A  = 4'd6;
    localparam logic [3:0] SEL_VAL_B  = 4'd7;
    localparam logic [3:0] SEL_STATUS = 4'd8;

    // status word layout
    localparam int ST_CODE_LSB = 8;
    localparam int ST_CNT_LSB  = 16;

endpackage

// File: rtl/ecc4_unpack.sv
module ecc4_unpack #(
    parameter int N_BYTES = 10,
    parameter int SYM_W   = 10,
    parameter int N_SYMS  = 8
) (
    input  logic [N_BYTES*8-1:0]     code,
    output logic [N_SYMS*SYM_W-1:0]  syms,
    output logic                     erased
);
    logic [N_BYTES-1:0] byte_ff;

    // little-endian byte string: symbol k is a contiguous bit slice
    for (genvar k = 0; k < N_SYMS; k++) begin : g_sym
        assign syms[k*SYM_W +: SYM_W] = code[k*SYM_W +: SYM_W];
    end

    for (genvar b = 0; b < N_BYTES; b++) begin : g_ff
        assign byte_ff[b] = &code[b*8 +: 8];
    end

    assign erased = &byte_ff;
endmodule

// File: rtl/ecc4_errmap.sv
module ecc4_errmap #(
    parameter int SECTOR_BYTES = 512,
    parameter int SYM_W        = 10,
    localparam int IDX_W       = $clog2(SECTOR_BYTES)
) (
    input  logic [SYM_W-1:0] err_addr,
    output logic [IDX_W-1:0] byte_idx,
    output logic             in_sector
);
    localparam int ADDR_OFS = SECTOR_BYTES + 7;
    localparam int LO       = ADDR_OFS - SECTOR_BYTES + 1;

    always_comb begin
        int diff;
        diff      = ADDR_OFS - int'(err_addr);
        byte_idx  = diff[IDX_W-1:0];
        in_sector = (int'(err_addr) >= LO) && (int'(err_addr) <= ADDR_OFS);
    end
endmodule

// File: rtl/ecc4_wait_timer.sv
module ecc4_wait_timer #(
    parameter int LIMIT = 200,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = (int'(cnt) >= LIMIT);
endmodule

// File: rtl/ecc4_corr_seq.sv
module ecc4_corr_seq
    import ecc4_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ECC_BYTES    = 10,
    parameter int SYM_W        = 10,
    parameter int N_SYMS       = 8,
    parameter int WAIT_LIMIT   = 200,
    localparam int IDX_W       = $clog2(SECTOR_BYTES),
    localparam int MAX_ERR     = 4,
    localparam int CNT_W       = $clog2(MAX_ERR + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ECC_BYTES*8-1:0] ecc_code,
    output logic                   eng_load_valid,
    output logic [SYM_W-1:0]       eng_load_data,
    output logic                   eng_calc_start,
    output logic                   eng_rd_en,
    output logic [3:0]             eng_rd_sel,
    input  logic [31:0]            eng_rd_data,
    output logic                   buf_xor_en,
    output logic [IDX_W-1:0]       buf_xor_idx,
    output logic [7:0]             buf_xor_val,
    output logic                   done,
    output logic [CNT_W-1:0]       corr_cnt,
    output logic                   uncorrectable
);
    localparam int SYN_WORDS = N_SYMS / 2;
    localparam int SI_W      = $clog2(N_SYMS);
    localparam int SW_W      = $clog2(SYN_WORDS);
    localparam logic [15:0] HALF_MASK = 16'((1 << SYM_W) - 1);
    localparam logic [31:0] SYN_MASK  = {HALF_MASK, HALF_MASK};

    seq_state_t state, nxt;

    logic [N_SYMS*SYM_W-1:0] syms;
    logic                    erased;
    logic [SI_W-1:0]         sym_idx;
    logic [SW_W-1:0]         syn_idx;
    logic                    syn_nz;
    logic [1:0]              err_idx, err_last;
    logic [IDX_W-1:0]        fix_idx, map_idx;
    logic                    fix_ok, map_ok;
    logic                    tmo;
    logic [CNT_W-1:0]        corr_q;
    logic                    uncorr_q;

    wire [3:0]  st_code  = eng_rd_data[ST_CODE_LSB +: 4];
    wire [1:0]  st_cnt   = eng_rd_data[ST_CNT_LSB +: 2];
    wire [15:0] err_half = err_idx[0] ? eng_rd_data[31:16] : eng_rd_data[15:0];
    wire        word_nz  = |(eng_rd_data & SYN_MASK);

    ecc4_unpack #(.N_BYTES(ECC_BYTES), .SYM_W(SYM_W), .N_SYMS(N_SYMS)) u_unpack (
        .code(ecc_code), .syms(syms), .erased(erased)
    );

    ecc4_errmap #(.SECTOR_BYTES(SECTOR_BYTES), .SYM_W(SYM_W)) u_map (
        .err_addr(err_half[SYM_W-1:0]), .byte_idx(map_idx), .in_sector(map_ok)
    );

    ecc4_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == S_ARM), .expired(tmo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = erased ? S_DONE : S_LOAD;
            S_LOAD:  if (sym_idx == '0) nxt = S_SYND;
            S_SYND:  if (int'(syn_idx) == SYN_WORDS - 1)
                         nxt = (syn_nz || word_nz) ? S_CLEAR : S_DONE;
            S_CLEAR: nxt = S_KICK;
            S_KICK:  nxt = S_ARM;
            S_ARM:   if (st_code >= 4'd4 || tmo) nxt = S_POLL;
            S_POLL:  begin
                if (st_code <= 4'd1)      nxt = S_TERM;
                else if (st_code <= 4'd3) nxt = S_FADDR;
            end
            S_TERM:  nxt = S_DONE;
            S_FADDR: nxt = S_FVAL;
            S_FVAL:  nxt = (err_idx == err_last) ? S_DONE : S_FADDR;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_load_valid = 1'b0;
        eng_load_data  = syms[sym_idx*SYM_W +: SYM_W];
        eng_calc_start = 1'b0;
        eng_rd_en      = 1'b0;
        eng_rd_sel     = SEL_STATUS;
        buf_xor_en     = 1'b0;
        done           = 1'b0;
        unique case (state)
            S_LOAD:  eng_load_valid = 1'b1;
            S_SYND:  begin
                eng_rd_en  = 1'b1;
                eng_rd_sel = SEL_SYN0 + 4'(syn_idx);
            end
            S_CLEAR: begin
                eng_rd_en  = 1'b1;
                eng_rd_sel = SEL_ADDR_A;
            end
            S_KICK:  eng_calc_start = 1'b1;
            S_ARM, S_POLL: eng_rd_en = 1'b1;
            S_TERM:  begin
                eng_rd_en  = 1'b1;
                eng_rd_sel = SEL_VAL_A;
            end
            S_FADDR: begin
                eng_rd_en  = 1'b1;
                eng_rd_sel = err_idx[1] ? SEL_ADDR_B : SEL_ADDR_A;
            end
            S_FVAL:  begin
                eng_rd_en  = 1'b1;
                eng_rd_sel = err_idx[1] ? SEL_VAL_B : SEL_VAL_A;
                buf_xor_en = fix_ok;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign buf_xor_idx   = fix_idx;
    assign buf_xor_val   = err_half[7:0];
    assign corr_cnt      = corr_q;
    assign uncorrectable = uncorr_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_idx  <= '0;
            syn_idx  <= '0;
            syn_nz   <= 1'b0;
            err_idx  <= '0;
            err_last <= '0;
            fix_idx  <= '0;
            fix_ok   <= 1'b0;
            corr_q   <= '0;
            uncorr_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    sym_idx  <= SI_W'(N_SYMS - 1);
                    syn_idx  <= '0;
                    syn_nz   <= 1'b0;
                    err_idx  <= '0;
                    corr_q   <= '0;
                    uncorr_q <= 1'b0;
                end
                S_LOAD: sym_idx <= sym_idx - 1'b1;
                S_SYND: begin
                    syn_idx <= syn_idx + 1'b1;
                    syn_nz  <= syn_nz | word_nz;
                end
                S_POLL: begin
                    if (st_code == 4'd1) uncorr_q <= 1'b1;
                    if (st_code == 4'd2 || st_code == 4'd3) err_last <= st_cnt;
                end
                S_FADDR: begin
                    fix_idx <= map_idx;
                    fix_ok  <= map_ok;
                end
                S_FVAL: begin
                    if (fix_ok) corr_q <= corr_q + 1'b1;
                    err_idx <= err_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ecc4_corr_seq_sva.sv
module ecc4_corr_seq_sva #(
    parameter int SYM_W = 10,
    parameter int IDX_W = 9,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eng_load_valid,
    input logic             eng_calc_start,
    input logic             eng_rd_en,
    input logic [3:0]       eng_rd_sel,
    input logic             buf_xor_en,
    input logic             done,
    input logic [CNT_W-1:0] corr_cnt,
    input logic             uncorrectable
);
    a_r2_load_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        eng_load_valid |-> (!eng_rd_en && !eng_calc_start));

    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_calc_start |=> !eng_calc_start);

    a_r4_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        eng_calc_start |-> $past(eng_rd_en && eng_rd_sel == 4'd4));

    a_r8_xor_on_value_read: assert property (@(posedge clk) disable iff (!rst_n)
        buf_xor_en |-> (eng_rd_en && (eng_rd_sel == 4'd6 || eng_rd_sel == 4'd7)));

    a_r6_uncorr_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> (corr_cnt == '0));

    a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (corr_cnt <= CNT_W'(4)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind ecc4_corr_seq ecc4_corr_seq_sva #(.SYM_W(SYM_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .eng_load_valid(eng_load_valid),
    .eng_calc_start(eng_calc_start), .eng_rd_en(eng_rd_en), .eng_rd_sel(eng_rd_sel),
    .buf_xor_en(buf_xor_en), .done(done), .corr_cnt(corr_cnt),
    .uncorrectable(uncorrectable)
);

// File: tb/ecc4_corr_seq_tb_top.sv
module ecc4_corr_seq_tb_top;
    localparam int WL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] ecc_code = '0;
    logic        eng_load_valid, eng_calc_start, eng_rd_en;
    logic [9:0]  eng_load_data;
    logic [3:0]  eng_rd_sel;
    logic [31:0] eng_rd_data;
    logic        buf_xor_en, done, uncorrectable;
    logic [8:0]  buf_xor_idx;
    logic [7:0]  buf_xor_val;
    logic [2:0]  corr_cnt;

    always #4 clk = ~clk;

    ecc4_corr_seq #(.WAIT_LIMIT(WL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ecc_code(ecc_code),
        .eng_load_valid(eng_load_valid), .eng_load_data(eng_load_data),
        .eng_calc_start(eng_calc_start), .eng_rd_en(eng_rd_en),
        .eng_rd_sel(eng_rd_sel), .eng_rd_data(eng_rd_data),
        .buf_xor_en(buf_xor_en), .buf_xor_idx(buf_xor_idx), .buf_xor_val(buf_xor_val),
        .done(done), .corr_cnt(corr_cnt), .uncorrectable(uncorrectable)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- stub engine ----------------
    logic [31:0] syn_w [4];
    int          f_len, b_len;
    bit          f_hold;
    logic [3:0]  fin_code;
    logic [1:0]  fin_cnt;
    logic [31:0] fin_aa, fin_ab, fin_va, fin_vb;
    int          phase = 0, pcnt = 0;
    logic [3:0]  st_code = 4'd0;
    logic [1:0]  st_cnt = 2'd0;
    logic [31:0] ra_a = 0, ra_b = 0, rv_a = 0, rv_b = 0;

    always @(posedge clk) begin
        if (eng_calc_start) begin
            pcnt <= 0;
            if (f_hold) begin
                phase <= 0; st_code <= 4'd3; st_cnt <= fin_cnt;
                ra_a <= fin_aa; ra_b <= fin_ab; rv_a <= fin_va; rv_b <= fin_vb;
            end else begin
                phase <= 1; st_code <= 4'd3; st_cnt <= 2'd0;
                ra_a <= 0; ra_b <= 0; rv_a <= 32'h00FF00FF; rv_b <= 32'h00FF00FF;
            end
        end else if (phase == 1 || phase == 2) begin
            pcnt <= pcnt + 1;
            if (pcnt + 1 >= (phase == 1 ? f_len : b_len)) begin
                pcnt <= 0;
                if (phase == 1 && b_len > 0) begin
                    phase <= 2; st_code <= 4'd6;
                end else begin
                    phase <= 3; st_code <= fin_code; st_cnt <= fin_cnt;
                    ra_a <= fin_aa; ra_b <= fin_ab; rv_a <= fin_va; rv_b <= fin_vb;
                end
            end
        end
    end

    always_comb begin
        case (eng_rd_sel)
            4'd0, 4'd1, 4'd2, 4'd3: eng_rd_data = syn_w[eng_rd_sel[1:0]];
            4'd4: eng_rd_data = ra_a;
            4'd5: eng_rd_data = ra_b;
            4'd6: eng_rd_data = rv_a;
            4'd7: eng_rd_data = rv_b;
            4'd8: eng_rd_data = {14'd0, st_cnt, 4'd0, st_code, 8'd0};
            default: eng_rd_data = 32'hDEAD_BEEF;
        endcase
    end

    // ---------------- monitors and buffer ----------------
    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];
    logic [9:0] load_log [16];
    int n_loads = 0, n_reads = 0, n_starts = 0, n_xor = 0;
    int cyc = 0, start_cyc = 0, done_cyc = 0;
    bit prev_clr = 0, clr_ok = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_clr <= eng_rd_en && eng_rd_sel == 4'd4;
        if (eng_load_valid) begin
            if (n_loads < 16) load_log[n_loads] <= eng_load_data;
            n_loads <= n_loads + 1;
        end
        if (eng_rd_en) n_reads <= n_reads + 1;
        if (eng_calc_start) begin
            n_starts <= n_starts + 1;
            start_cyc <= cyc;
            clr_ok <= prev_clr;
        end
        if (buf_xor_en) begin
            mem[buf_xor_idx] <= mem[buf_xor_idx] ^ buf_xor_val;
            n_xor <= n_xor + 1;
        end
        if (done) done_cyc <= cyc;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic prep(input logic [79:0] code);
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        n_loads = 0; n_reads = 0; n_starts = 0; n_xor = 0; clr_ok = 0;
        f_len = 4; b_len = 5; f_hold = 0;
        fin_code = 4'd2; fin_cnt = 2'd0;
        fin_aa = 0; fin_ab = 0; fin_va = 0; fin_vb = 0;
        for (int i = 0; i < 4; i++) syn_w[i] = 32'h0;
        ecc_code = code;
    endtask

    task automatic run_sector(input string tag);
        int n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, {tag, " done seen"}, done, 1);
        @(negedge clk);
        check(done == 1'b0, "R9 done is one cycle", done, 0);
    endtask

    task automatic check_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, {tag, " buffer contents"}, bad, 0);
    endtask

    task automatic check_loads(input logic [79:0] code);
        int bad = 0;
        check(n_loads == 8, "R2 load count", n_loads, 8);
        for (int j = 0; j < 8; j++)
            if (load_log[j] !== code[(7 - j) * 10 +: 10]) bad++;
        check(bad == 0, "R2 load order value7..value0", bad, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(done == 0 && eng_load_valid == 0 && eng_rd_en == 0 && eng_calc_start == 0,
              "R9 reset outputs idle", done, 0);
        check(corr_cnt == 0 && uncorrectable == 0, "R9 reset status", corr_cnt, 0);
    endtask

    task automatic t_erased();
        int n;
        prep({10{8'hFF}});
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(done == 1'b1, "R1 done one cycle after start", done, 1);
        n = n_loads + n_reads + n_starts;
        check(n == 0, "R1 no engine access", n, 0);
        check(corr_cnt == 0 && uncorrectable == 0, "R1 zero errors", corr_cnt, 0);
        @(negedge clk);
    endtask

    task automatic t_zero_syn();
        logic [79:0] c = 80'h5A3C_0F12_7788_E1D2_9B46;
        prep(c);
        for (int i = 0; i < 4; i++) syn_w[i] = 32'hFC00_FC00;
        run_sector("R3");
        check_loads(c);
        check(n_reads == 4, "R3 four syndrome reads", n_reads, 4);
        check(n_starts == 0, "R3 no location start on masked-zero syndrome", n_starts, 0);
        check(corr_cnt == 0 && uncorrectable == 0, "R3 no errors", corr_cnt, 0);
    endtask

    task automatic t_single();
        logic [79:0] c = 80'hFFFF_FFFF_FFFF_FFFF_FFFE;
        prep(c);
        syn_w[2] = 32'h0000_0100;
        fin_aa = 32'(519 - 100); fin_va = 32'h24;
        exp_mem[100] = exp_mem[100] ^ 8'h24;
        run_sector("R7 single");
        check_loads(c);
        check(n_starts == 1, "R4 one start pulse", n_starts, 1);
        check(clr_ok == 1, "R4 clear read precedes start", clr_ok, 1);
        check(corr_cnt == 1, "R7 single corrected", corr_cnt, 1);
        check(done_cyc - start_cyc > 4 + 5, "R5 waited past false complete", done_cyc - start_cyc, 10);
        check_mem("R8 single");
    endtask

    task automatic t_four();
        prep(80'h0102_0304_0506_0708_090A);
        syn_w[0] = 32'h0000_0001;
        fin_code = 4'd3; fin_cnt = 2'd3;
        fin_aa = {16'd8, 16'd514};    // idx 5, idx 511
        fin_ab = {16'd219, 16'd519};  // idx 0, idx 300
        fin_va = {16'h0081, 16'h0011};
        fin_vb = {16'h00C0, 16'h0002};
        exp_mem[5]   ^= 8'h11; exp_mem[511] ^= 8'h81;
        exp_mem[0]   ^= 8'h02; exp_mem[300] ^= 8'hC0;
        run_sector("R7 four");
        check(corr_cnt == 4, "R7 four corrected", corr_cnt, 4);
        check(uncorrectable == 0, "R7 four not uncorrectable", uncorrectable, 0);
        check_mem("R7 R8 four halves and pairs");
        repeat (3) @(negedge clk);
        check(corr_cnt == 4, "R9 count held after done", corr_cnt, 4);
    endtask

    task automatic t_out_of_range();
        prep(80'h1111_2222_3333_4444_5555);
        syn_w[3] = 32'h0200_0000;
        fin_cnt = 2'd2;
        fin_aa = {16'd600, 16'd3};
        fin_ab = {16'd0, 16'd420};
        fin_va = {16'h0033, 16'h0044};
        fin_vb = {16'h0000, 16'h0055};
        exp_mem[99] ^= 8'h55;
        run_sector("R8 range");
        check(corr_cnt == 1, "R8 only in-sector counted", corr_cnt, 1);
        check(n_xor == 1, "R8 only in-sector stroke", n_xor, 1);
        check_mem("R8 range");
    endtask

    task automatic t_uncorr();
        prep(80'h0F0F_0F0F_0F0F_0F0F_0F0F);
        syn_w[1] = 32'h0001_0000;
        fin_code = 4'd1; fin_aa = 32'd10; fin_va = 32'h77;
        run_sector("R6 uncorr");
        check(uncorrectable == 1, "R6 five-plus flagged", uncorrectable, 1);
        check(corr_cnt == 0 && n_xor == 0, "R6 no stroke when uncorrectable", n_xor, 0);
        check_mem("R6 uncorr");
    endtask

    task automatic t_code0();
        prep(80'h00FF_00FF_00FF_00FF_00FE);
        syn_w[0] = 32'h0000_0010;
        fin_code = 4'd0;
        run_sector("R6 code0");
        check(uncorrectable == 0 && corr_cnt == 0 && n_xor == 0, "R6 code 0 clean", n_xor, 0);
    endtask

    task automatic t_timeout();
        prep(80'hABCD_EF01_2345_6789_ABCD);
        syn_w[0] = 32'h0000_0001;
        f_hold = 1;
        fin_aa = 32'(519 - 7); fin_va = 32'h5A;
        exp_mem[7] ^= 8'h5A;
        run_sector("R5 timeout");
        check(done_cyc - start_cyc > WL, "R5 waits WAIT_LIMIT before accepting 3",
              done_cyc - start_cyc, WL + 1);
        check(corr_cnt == 1, "R5 correction after timeout", corr_cnt, 1);
        check_mem("R5 timeout");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_erased();
        t_zero_syn();
        t_single();
        t_four();
        t_out_of_range();
        t_uncorr();
        t_code0();
        t_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule